// File: doc/BRIEF.md
# Packed Integer Vector Arithmetic Unit

This block performs one integer operation across a 128-bit vector per accepted request. Each operand is cut into independent lanes whose width is picked per request: sixteen 8-bit, eight 16-bit, four 32-bit or two 64-bit lanes. All lanes see the same operation at once, and nothing computed in one lane spills into its neighbour.

The operations are wrapping add and subtract at any lane width, byte-only saturating add in signed and unsigned forms, a multiply that keeps the low half of each 16-bit or 32-bit lane product, and two compares (equal, signed greater-than) that fill each lane with all ones when true and all zeros when false. A request is presented with a valid strobe. The result, a valid flag and an illegal-combination flag appear registered on the next clock edge. The registered result holds until the next accepted request.

Top module: `simd_int_alu`

## Requirements
- R1: Opcode codes are add=0, sub=1, signed saturating add=2, unsigned saturating add=3, low multiply=4, equal=5, greater=6. Lane codes are 0=8-bit, 1=16-bit, 2=32-bit, 3=64-bit. An add wraps within each lane of the chosen width, and no carry passes from one lane into the next.
- R2: A subtract works at every lane width, wraps modulo the lane width, and no borrow passes between lanes.
- R3: With lane code 0, a signed saturating add clamps each byte sum into -128..+127 (0x80..0x7F).
- R4: With lane code 0, an unsigned saturating add clamps each byte sum to 255 (0xFF).
- R5: A low multiply with lane code 1 or 2 returns the low 16 or 32 bits of each lane product.
- R6: An equal compare sets each lane to all ones when the lanes match and to zero otherwise, at every width.
- R7: A greater compare treats lanes as two's-complement signed values and sets a lane to all ones when the first operand is larger, zero otherwise.
- R8: Saturating adds with any lane code other than 0, a low multiply with lane code 0 or 3, and opcode 7 give a zero result with the illegal flag high. Every legal request clears the flag.
- R9: The result and both flags change only on a cycle with the valid strobe high. The output valid is the input strobe delayed by exactly one clock.
- R10: A synchronous active-high reset clears the result, the output valid and the illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Request strobe |
| op_a_i | input | 128 | First vector operand |
| op_b_i | input | 128 | Second vector operand |
| opcode_i | input | 3 | Operation code |
| lane_i | input | 2 | Lane width code |
| res_o | output | 128 | Registered result vector |
| res_valid_o | output | 1 | Result valid, one cycle after the strobe |
| illegal_o | output | 1 | Unsupported opcode and lane combination |

## Verification
Several properties are checked on every clock. The one-cycle valid delay and the holding of the result while idle are checked this way. So are the zero result on opcode 7 and the byte-level all-ones/all-zeros shape of compare results. Two identities are also checked each cycle: adding zero returns the first operand, and subtracting a value from itself returns zero. The specific values depend on operand data that no local property captures. These values are the carry and borrow cut at each lane width, the saturation points of both byte adds, the truncation of products, and the signed ordering in compares. Only the bench's vector table shows them, together with the directed checks for idle holding and for reset in mid-run.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int VEC_W_DEF = 128;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_SADDS = 3'd2,
        OP_UADDS = 3'd3,
        OP_MULLO = 3'd4,
        OP_CMPEQ = 3'd5,
        OP_CMPGT = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        LN_8  = 2'd0,
        LN_16 = 2'd1,
        LN_32 = 2'd2,
        LN_64 = 2'd3
    } lane_e;

    // Whether an opcode may be used with a lane width
    function automatic logic pair_ok(op_e op, lane_e ln);
        logic ok;
        case (op)
            OP_ADD, OP_SUB, OP_CMPEQ, OP_CMPGT: ok = 1'b1;
            OP_SADDS, OP_UADDS:                 ok = (ln == LN_8);
            OP_MULLO:                           ok = (ln == LN_16) || (ln == LN_32);
            default:                            ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Bytes per lane for a lane code
    function automatic int lane_bytes(lane_e ln);
        return 1 << int'(ln);
    endfunction

endpackage

// File: rtl/pk_addsub.sv
module pk_addsub
    import simd_alu_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEF
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  logic             sub_i,
    input  lane_e            lane_i,
    output logic [VEC_W-1:0] y_o
);
    localparam int NB = VEC_W / 8;

    // Byte-serial ripple; carry re-seeded at every lane start
    always_comb begin
        logic       c;
        logic [8:0] s;
        int         lb;
        lb  = lane_bytes(lane_i);
        c   = 1'b0;
        s   = '0;
        y_o = '0;
        for (int i = 0; i < NB; i++) begin
            if ((i % lb) == 0) c = sub_i;
            s = {1'b0, a_i[i*8 +: 8]} + {1'b0, b_i[i*8 +: 8] ^ {8{sub_i}}} + {8'd0, c};
            y_o[i*8 +: 8] = s[7:0];
            c = s[8];
        end
    end
endmodule

// File: rtl/pk_satbyte.sv
module pk_satbyte
    import simd_alu_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEF
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  logic             signed_i,
    output logic [VEC_W-1:0] y_o
);
    localparam int NB = VEC_W / 8;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        logic [7:0] ab, bb;
        logic [8:0] us, ss;
        logic [7:0] u_clamp, s_clamp;
        assign ab = a_i[g*8 +: 8];
        assign bb = b_i[g*8 +: 8];
        assign us = {1'b0, ab} + {1'b0, bb};
        assign ss = {ab[7], ab} + {bb[7], bb};
        assign u_clamp = us[8] ? 8'hFF : us[7:0];
        // sign of 9-bit sum differs from bit 7 -> out of byte range
        assign s_clamp = (ss[8] != ss[7]) ? (ss[8] ? 8'h80 : 8'h7F) : ss[7:0];
        assign y_o[g*8 +: 8] = signed_i ? s_clamp : u_clamp;
    end
endmodule

// File: rtl/pk_mullo.sv
module pk_mullo
    import simd_alu_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEF
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  lane_e            lane_i,
    output logic [VEC_W-1:0] y_o
);
    localparam int NH = VEC_W / 16;
    localparam int NW = VEC_W / 32;

    logic [VEC_W-1:0] m16, m32;

    for (genvar h = 0; h < NH; h++) begin : g_half
        logic [15:0] lo;
        assign lo = a_i[h*16 +: 16] * b_i[h*16 +: 16];
        assign m16[h*16 +: 16] = lo;
    end

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [31:0] lo;
        assign lo = a_i[w*32 +: 32] * b_i[w*32 +: 32];
        assign m32[w*32 +: 32] = lo;
    end

    assign y_o = (lane_i == LN_32) ? m32 : m16;
endmodule

// File: rtl/pk_cmp.sv
module pk_cmp
    import simd_alu_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEF
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  logic             gt_i,
    input  lane_e            lane_i,
    output logic [VEC_W-1:0] y_o
);
    localparam int NSZ = 4;

    logic [VEC_W-1:0] msk [NSZ];

    for (genvar s = 0; s < NSZ; s++) begin : g_size
        localparam int LW = 8 << s;
        localparam int NL = VEC_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic hit;
            assign hit = gt_i ? ($signed(a_i[l*LW +: LW]) > $signed(b_i[l*LW +: LW]))
                              : (a_i[l*LW +: LW] == b_i[l*LW +: LW]);
            assign msk[s][l*LW +: LW] = {LW{hit}};
        end
    end

    assign y_o = msk[lane_i];
endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu
    import simd_alu_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             in_valid_i,
    input  logic [VEC_W-1:0] op_a_i,
    input  logic [VEC_W-1:0] op_b_i,
    input  logic [2:0]       opcode_i,
    input  logic [1:0]       lane_i,
    output logic [VEC_W-1:0] res_o,
    output logic             res_valid_o,
    output logic             illegal_o
);
    op_e   op;
    lane_e ln;
    assign op = op_e'(opcode_i);
    assign ln = lane_e'(lane_i);

    logic [VEC_W-1:0] y_add, y_sat, y_mul, y_cmp;
    logic [VEC_W-1:0] nxt;
    logic             legal;

    pk_addsub #(.VEC_W(VEC_W)) u_add (
        .a_i(op_a_i), .b_i(op_b_i), .sub_i(op == OP_SUB), .lane_i(ln), .y_o(y_add)
    );

    pk_satbyte #(.VEC_W(VEC_W)) u_sat (
        .a_i(op_a_i), .b_i(op_b_i), .signed_i(op == OP_SADDS), .y_o(y_sat)
    );

    pk_mullo #(.VEC_W(VEC_W)) u_mul (
        .a_i(op_a_i), .b_i(op_b_i), .lane_i(ln), .y_o(y_mul)
    );

    pk_cmp #(.VEC_W(VEC_W)) u_cmp (
        .a_i(op_a_i), .b_i(op_b_i), .gt_i(op == OP_CMPGT), .lane_i(ln), .y_o(y_cmp)
    );

    always_comb begin
        legal = pair_ok(op, ln);
        case (op)
            OP_ADD, OP_SUB:     nxt = y_add;
            OP_SADDS, OP_UADDS: nxt = y_sat;
            OP_MULLO:           nxt = y_mul;
            OP_CMPEQ, OP_CMPGT: nxt = y_cmp;
            default:            nxt = '0;
        endcase
        if (!legal) nxt = '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            res_o       <= '0;
            res_valid_o <= 1'b0;
            illegal_o   <= 1'b0;
        end else begin
            res_valid_o <= in_valid_i;
            if (in_valid_i) begin
                res_o     <= nxt;
                illegal_o <= !legal;
            end
        end
    end
endmodule

// File: rtl/simd_int_alu_chk.sv
module simd_int_alu_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             in_valid_i,
    input logic [VEC_W-1:0] op_a_i,
    input logic [VEC_W-1:0] op_b_i,
    input logic [2:0]       opcode_i,
    input logic [1:0]       lane_i,
    input logic [VEC_W-1:0] res_o,
    input logic             res_valid_o,
    input logic             illegal_o
);
    function automatic logic bytes_solid(logic [VEC_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < VEC_W / 8; i++)
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
        return ok;
    endfunction

    // R9
    valid_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> res_valid_o);

    // R9
    valid_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> !res_valid_o);

    // R9
    hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> ($stable(res_o) && $stable(illegal_o)));

    // R8
    reserved_op_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && opcode_i == 3'd7) |=> (illegal_o && res_o == '0));

    // R1
    add_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && opcode_i == 3'd0 && op_b_i == '0) |=> (res_o == $past(op_a_i)));

    // R2
    sub_self_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && opcode_i == 3'd1 && op_a_i == op_b_i) |=> (res_o == '0));

    // R6 R7
    cmp_mask_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && (opcode_i == 3'd5 || opcode_i == 3'd6)) |=> bytes_solid(res_o));
endmodule

bind simd_int_alu simd_int_alu_chk #(.VEC_W(VEC_W)) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .in_valid_i(in_valid_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .opcode_i(opcode_i), .lane_i(lane_i),
    .res_o(res_o), .res_valid_o(res_valid_o), .illegal_o(illegal_o)
);

// File: tb/simd_int_alu_test.sv
`timescale 1ns/1ps
module simd_int_alu_test;

    typedef struct packed {
        logic [3:0]   req;
        logic [2:0]   op;
        logic [1:0]   ln;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
        logic         ill;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        // R1 byte add wraps, no carry out of byte 0
        '{4'd1, 3'd0, 2'd0, 128'hFF, 128'h01, 128'h0, 1'b0},
        // R1 halfword add carries inside lane
        '{4'd1, 3'd0, 2'd1, 128'hFF, 128'h01, 128'h100, 1'b0},
        // R1 word add, lane 0 wraps, lane 1 independent
        '{4'd1, 3'd0, 2'd2, 128'hFFFFFFFF, 128'h00000001_00000001, 128'h00000001_00000000, 1'b0},
        // R1 doubleword add wraps, no carry into upper lane
        '{4'd1, 3'd0, 2'd3, 128'hFFFFFFFF_FFFFFFFF, 128'h1, 128'h0, 1'b0},
        // R2 byte subtract borrow stays in lane
        '{4'd2, 3'd1, 2'd0, 128'h0, 128'h01, 128'hFF, 1'b0},
        // R2 doubleword subtract
        '{4'd2, 3'd1, 2'd3, 128'h0, 128'h1, 128'hFFFFFFFF_FFFFFFFF, 1'b0},
        // R2 halfword subtract
        '{4'd2, 3'd1, 2'd1, 128'h0005_0003, 128'h0001_0004, 128'h0004_FFFF, 1'b0},
        // R3 signed saturation high, low, in range
        '{4'd3, 3'd2, 2'd0, 128'h10_80_7F, 128'h20_FF_01, 128'h30_80_7F, 1'b0},
        // R4 unsigned saturation
        '{4'd4, 3'd3, 2'd0, 128'h10_FF_F0, 128'h20_01_20, 128'h30_FF_FF, 1'b0},
        // R5 16-bit low product
        '{4'd5, 3'd4, 2'd1, 128'h0100_0003, 128'h0100_0005, 128'h0000_000F, 1'b0},
        // R5 32-bit low product
        '{4'd5, 3'd4, 2'd2, 128'h00010000_00000007, 128'h00010000_00000009, 128'h3F, 1'b0},
        // R6 byte equality
        '{4'd6, 3'd5, 2'd0, 128'h0A0B, 128'h0A0C, ~128'hFF, 1'b0},
        // R6 doubleword equality
        '{4'd6, 3'd5, 2'd3, 128'h5, 128'h5, ~128'h0, 1'b0},
        // R7 signed word greater
        '{4'd7, 3'd6, 2'd2, 128'hFFFFFFFF_00000001, 128'h0, 128'hFFFFFFFF, 1'b0},
        // R7 signed byte: -128 not greater than 127
        '{4'd7, 3'd6, 2'd0, 128'h80, 128'h7F, 128'h0, 1'b0},
        // R7 signed byte: positive beats -128
        '{4'd7, 3'd6, 2'd0, 128'h01_7F, 128'h80_80, 128'hFFFF, 1'b0},
        // R8 saturating add at halfword width
        '{4'd8, 3'd2, 2'd1, 128'h1, 128'h1, 128'h0, 1'b1},
        // R8 multiply at byte width
        '{4'd8, 3'd4, 2'd0, 128'h3, 128'h3, 128'h0, 1'b1},
        // R8 reserved opcode
        '{4'd8, 3'd7, 2'd2, 128'h3, 128'h3, 128'h0, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] op_a = '0, op_b = '0;
    logic [2:0]   opcode = '0;
    logic [1:0]   lane = '0;
    logic [127:0] res;
    logic         res_valid, illegal;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    simd_int_alu uut (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid),
        .op_a_i(op_a), .op_b_i(op_b), .opcode_i(opcode), .lane_i(lane),
        .res_o(res), .res_valid_o(res_valid), .illegal_o(illegal)
    );

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [2:0] o, logic [1:0] l, logic [127:0] a, logic [127:0] b);
        @(negedge clk);
        opcode = o; lane = l; op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 state after reset
        check("R10 reset result", res, '0);
        check("R10 reset valid", {127'd0, res_valid}, '0);
        check("R10 reset illegal", {127'd0, illegal}, '0);

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].op, TBL[i].ln, TBL[i].a, TBL[i].b);
            check($sformatf("R%0d vec %0d result", TBL[i].req, i), res, TBL[i].exp);
            check($sformatf("R%0d vec %0d illegal", TBL[i].req, i), {127'd0, illegal}, {127'd0, TBL[i].ill});
            check($sformatf("R9 vec %0d valid", i), {127'd0, res_valid}, 128'd1);
        end

        // R8 legal request clears the illegal flag
        issue(3'd0, 2'd0, 128'h0102, 128'h0101);
        check("R8 flag cleared", {127'd0, illegal}, '0);
        check("R1 byte add", res, 128'h0203);

        // R9 idle cycle: operands change, outputs hold
        op_a = 128'hDEAD; op_b = 128'hBEEF; opcode = 3'd1;
        @(negedge clk);
        check("R9 hold result", res, 128'h0203);
        check("R9 valid low when idle", {127'd0, res_valid}, '0);

        // R10 reset in mid-run
        issue(3'd5, 2'd3, 128'h7, 128'h7);
        check("R6 before reset", res, ~128'h0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 mid-run reset result", res, '0);
        check("R10 mid-run reset valid", {127'd0, res_valid}, '0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule